// File: doc/BRIEF.md
# GPIO Port with Interrupt Detection

This block is a 32-pin general-purpose I/O port that software reaches through a small register file. Each register is one word wide and sits at a fixed byte offset. Each pin has an output level, a direction, and an interrupt source that can be configured. The block does not drive pads itself. It presents an output vector and an output-enable vector, and it receives an input vector from the pads.

Each pin's input passes through a two-flop synchroniser. It then reaches a detector that fires on one of four trigger conditions: low level, high level, rising edge or falling edge. Detected events latch into a status register that software clears by writing ones. A mask register decides which latched bits reach the interrupt line. That line is the registered OR of status AND mask.

Top module: `gpio_irq_port`

## Requirements
- R1: While `rst` is high, every register resets to zero. This includes data, direction, both trigger configurations, mask and status. `pin_out`, `pin_oe`, `irq` and `rd_data` all read zero.
- R2: Writing offset 0x00 loads the output-level register. `pin_out[n]` follows bit n from the next cycle, and a read of 0x00 returns the stored value.
- R3: Writing offset 0x04 loads the direction register, where a 1 in bit n makes pin n an output. `pin_oe` equals this register from the next cycle, and a read of 0x04 returns it.
- R4: A read of offset 0x08 returns the pin inputs after a two-flop synchroniser. Writes to 0x08 change nothing.
- R5: Offset 0x0C holds the trigger modes of pins 0 to 15, and offset 0x10 holds those of pins 16 to 31. Each pin has a 2-bit field at bit 2*(n mod 16). The field encodes 00 as low level, 01 as high level, 10 as rising edge and 11 as falling edge.
- R6: In rising mode, a 0-to-1 change of the synchronised input sets status bit n. In falling mode, a 1-to-0 change sets it. A steady input sets nothing.
- R7: In a level mode, status bit n is set on every cycle the level persists. When a clear and an event arrive in the same cycle, the bit stays set.
- R8: Offset 0x18 is the status register. Writing a 1 to bit n clears that bit, and writing 0 bits leaves them unchanged.
- R9: Offset 0x14 is the mask register, and a 1 in bit n lets status bit n reach `irq`. Status bits still latch while they are masked.
- R10: `irq` is registered. It is high exactly one cycle after (status AND mask) is non-zero.
- R11: Read data appears on `rd_data` one cycle after `addr` is presented. A read of an unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 5 | Byte offset of the register |
| wr_en | input | 1 | Write strobe for the offset on `addr` |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| pin_in | input | 32 | Pad input levels (asynchronous) |
| pin_out | output | 32 | Output levels to the pads |
| pin_oe | output | 32 | Output enables, 1 = drive |
| irq | output | 1 | Interrupt request |

## Verification
The bench sets a random mode for every pin, settles the inputs on one random pattern, clears all status bits and then applies a second pattern. It then compares the status word with a value computed per pin from the mode and the two patterns. A design that places a field in the wrong half or at the wrong bit offset, or that swaps rising with falling, gives a mismatched pin. The bench also clears a bit whose level condition still holds. A design that lets the clear win would report that bit as clear when it should read set. Two further cases are a write of zeros to status and interrupts while fully masked. A design that treats a write as a load, or that gates the latching with the mask, would lose status bits.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_DATA   = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR    = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_PAD    = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_CFG_LO = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_CFG_HI = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 5'h18;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;
endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_port_detect.sv
module gpio_port_detect
  import gpio_port_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] lvl,
  input  logic [NPIN-1:0] cfg_lo,
  input  logic [NPIN-1:0] cfg_hi,
  output logic [NPIN-1:0] evt
);
  localparam int HALF = NPIN / 2;

  logic [NPIN-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic [1:0] mode;
    if (g < HALF) begin : g_lo
      assign mode = cfg_lo[2*g +: 2];
    end else begin : g_hi
      assign mode = cfg_hi[2*(g-HALF) +: 2];
    end

    always_comb begin
      unique case (trig_e'(mode))
        TRIG_LOW:  evt[g] = ~lvl[g];
        TRIG_HIGH: evt[g] =  lvl[g];
        TRIG_RISE: evt[g] =  lvl[g] & ~prev_q[g];
        TRIG_FALL: evt[g] = ~lvl[g] &  prev_q[g];
        default:   evt[g] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port_status.sv
module gpio_port_status #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] evt,
  input  logic [NPIN-1:0] clr,
  input  logic [NPIN-1:0] mask,
  output logic [NPIN-1:0] stat,
  output logic            irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
      irq  <= 1'b0;
    end else begin
      stat <= (stat & ~clr) | evt;
      irq  <= |(stat & mask);
    end
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_port_pkg::*;
#(
  parameter int NPIN      = 32,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [NPIN-1:0]   wr_data,
  output logic [NPIN-1:0]   rd_data,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic              irq
);
  logic [NPIN-1:0] data_q, dir_q, cfg_lo_q, cfg_hi_q, mask_q;
  logic [NPIN-1:0] pad_s, evt, clr, stat_q;

  gpio_port_sync #(.W(NPIN), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pad_s)
  );

  gpio_port_detect #(.NPIN(NPIN)) u_detect (
    .clk(clk), .rst(rst), .lvl(pad_s),
    .cfg_lo(cfg_lo_q), .cfg_hi(cfg_hi_q), .evt(evt)
  );

  assign clr = (wr_en && addr == OFS_STAT) ? wr_data : '0;

  gpio_port_status #(.NPIN(NPIN)) u_status (
    .clk(clk), .rst(rst), .evt(evt), .clr(clr),
    .mask(mask_q), .stat(stat_q), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q   <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
    end else if (wr_en) begin
      unique case (addr)
        OFS_DATA:   data_q   <= wr_data;
        OFS_DIR:    dir_q    <= wr_data;
        OFS_CFG_LO: cfg_lo_q <= wr_data;
        OFS_CFG_HI: cfg_hi_q <= wr_data;
        OFS_MASK:   mask_q   <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      unique case (addr)
        OFS_DATA:   rd_data <= data_q;
        OFS_DIR:    rd_data <= dir_q;
        OFS_PAD:    rd_data <= pad_s;
        OFS_CFG_LO: rd_data <= cfg_lo_q;
        OFS_CFG_HI: rd_data <= cfg_hi_q;
        OFS_MASK:   rd_data <= mask_q;
        OFS_STAT:   rd_data <= stat_q;
        default:    rd_data <= '0;
      endcase
    end
  end

  assign pin_out = data_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int NPIN = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [NPIN-1:0]   wr_data,
  input logic [NPIN-1:0]   pin_out,
  input logic [NPIN-1:0]   pin_oe,
  input logic              irq,
  input logic [NPIN-1:0]   stat,
  input logic [NPIN-1:0]   mask,
  input logic [NPIN-1:0]   evt
);
  AST_DATA_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_DATA) |=> (pin_out == $past(wr_data))); // R2

  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_DIR) |=> (pin_oe == $past(wr_data))); // R3

  AST_EVENT_LATCH: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> ((stat & $past(evt)) == $past(evt))); // R6

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_STAT) |=> ((stat & $past(wr_data & ~evt)) == '0)); // R8

  AST_STICKY_STATUS: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == OFS_STAT) |=> ((stat & $past(stat)) == $past(stat))); // R9

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (irq == |($past(stat & mask)))); // R10
endmodule

bind gpio_irq_port gpio_port_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
  .stat(stat_q), .mask(mask_q), .evt(evt)
);

// File: tb/test_gpio_irq_port.sv
`timescale 1ns/1ps
module test_gpio_irq_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_port i_gpio_irq_port (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    @(posedge clk);
    #1 d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // status after settle on a, clear all, then settle on b (R5, R6, R7)
  function automatic logic [31:0] exp_stat(input logic [63:0] m, input logic [31:0] a,
                                           input logic [31:0] b);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      case (m[2*i +: 2])
        2'b00:   r[i] = ~a[i] | ~b[i];
        2'b01:   r[i] =  a[i] |  b[i];
        2'b10:   r[i] = ~a[i] &  b[i];
        default: r[i] =  a[i] & ~b[i];
      endcase
    end
    return r;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, a0, b0, msk;
    logic [63:0] modes;
    void'($urandom(32'd7321));
    pin_in = 32'hFFFF_0000;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values
    chk("R1 rd_data", rd_data, '0);
    chk("R1 pin_out", pin_out, '0);
    chk("R1 pin_oe", pin_oe, '0);
    chk("R1 irq", {31'b0, irq}, '0);
    @(negedge clk);
    rst = 1'b0;

    // R2 / R3 random data and direction
    for (int k = 0; k < 12; k++) begin
      a0 = $urandom; b0 = $urandom;
      wr(5'h00, a0);
      wr(5'h04, b0);
      chk("R2 pin_out", pin_out, a0);
      chk("R3 pin_oe", pin_oe, b0);
      rd(5'h00, v); chk("R2 readback", v, a0);
      rd(5'h04, v); chk("R3 readback", v, b0);
    end

    // R4 pad status, writes ignored
    @(negedge clk); pin_in = 32'hA5C3_0F96;
    idle(3);
    wr(5'h08, 32'h1234_5678);
    rd(5'h08, v); chk("R4 pad sync", v, 32'hA5C3_0F96);

    // R11 unmapped offset
    rd(5'h1C, v); chk("R11 unmapped", v, '0);

    // R5 / R6 / R7 random modes against two patterns
    for (int k = 0; k < 30; k++) begin
      modes = {$urandom, $urandom};
      if (k == 0) modes = {32'hFFFF_FFFF, 32'hAAAA_AAAA};
      a0 = $urandom; b0 = $urandom;
      wr(5'h14, '0);
      wr(5'h0C, modes[31:0]);
      wr(5'h10, modes[63:32]);
      @(negedge clk); pin_in = a0;
      idle(4);
      wr(5'h18, 32'hFFFF_FFFF);
      @(negedge clk); pin_in = b0;
      idle(4);
      rd(5'h18, v); chk("R5 R6 R7 status", v, exp_stat(modes, a0, b0));
      // R9 masked bits still latched, R10 irq
      msk = $urandom;
      if (k == 1) msk = '0;
      wr(5'h14, msk);
      idle(2);
      chk("R10 irq", {31'b0, irq}, {31'b0, |(exp_stat(modes, a0, b0) & msk)});
      rd(5'h14, v); chk("R9 mask readback", v, msk);
    end

    // R7 directed: high level on pin 3, clear does not stick while level holds
    wr(5'h0C, 32'h0000_0040 | 32'hAAAA_AAAA & ~32'h0000_00C0);
    wr(5'h10, 32'hAAAA_AAAA);
    @(negedge clk); pin_in = 32'h0000_0008;
    idle(4);
    wr(5'h18, 32'hFFFF_FFFF);
    rd(5'h18, v); chk("R7 level persists", v, 32'h0000_0008);
    @(negedge clk); pin_in = '0;
    idle(4);
    wr(5'h18, 32'h0000_0008);
    rd(5'h18, v); chk("R7 clear after level gone", v, '0);

    // R5 directed: pin 16 rising lives in high register bits [1:0]
    wr(5'h10, 32'hFFFF_FFFE);
    idle(2);
    wr(5'h18, 32'hFFFF_FFFF);
    @(negedge clk); pin_in = 32'h0001_0000;
    idle(4);
    rd(5'h18, v); chk("R5 pin16 rising", v, 32'h0001_0000);

    // R8 zero write has no effect, one write clears
    wr(5'h18, 32'h0000_0000);
    rd(5'h18, v); chk("R8 zero write", v, 32'h0001_0000);
    // R9 masked: no irq but still latched
    wr(5'h14, '0);
    idle(2);
    chk("R9 masked irq", {31'b0, irq}, '0);
    wr(5'h14, 32'h0001_0000);
    idle(2);
    chk("R10 irq on unmask", {31'b0, irq}, 32'h1);
    wr(5'h18, 32'h0001_0000);
    rd(5'h18, v); chk("R8 one clears", v, '0);
    idle(2);
    chk("R10 irq drops", {31'b0, irq}, '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule